// File: doc/BRIEF.md
# Round-Robin Assertion Thread Dispatcher

This block wraps a small temporal checker so that several identical copies of it run side by side. Each cycle on which the trigger (the precondition of an implication) is true produces one token. A rotating one-hot pointer hands that token to exactly one copy, then moves to the next copy. Each copy tracks a fixed consequent: after its token, step input 0 must be true one cycle later, step input 1 two cycles later, and so on for `STEPS` steps. The copies' registered flags are exposed as a vector, and their OR forms a single verdict. Seen from outside, the verdict is what one unthreaded checker would give. The flag vector and the pointer together tell a debugger how many triggers ago, modulo the thread count, the offending trigger was issued.

A parameter selects the copy's variant. In failure mode a copy flags when an awaited step is missing, which is the consequent side of an implication. In match mode a copy flags when a trigger is followed by every step in turn, which is the antecedent side. Thread count is a parameter restricted to 2, 4 or 8, and the step count to 1..8. Both limits are enforced at elaboration. Area grows linearly with the thread count.

Top module: `assert_thread_dispatch`

## Requirements
- R1: While rst_n is low, and after the first clock edge with rst_n low, ptr_o equals 1 (thread 0 selected), thread_hit_o is all zero and verdict_o is 0.
- R2: On a clock edge where trig_i is 1, ptr_o moves from bit i to bit i+1, and from bit N_THREADS-1 back to bit 0. On an edge where trig_i is 0, ptr_o keeps its value.
- R3: Out of reset, ptr_o has exactly one bit set in every cycle.
- R4: A trigger sampled while ptr_o has bit i set is delivered to thread i only. In failure mode, if steps_i[0] is 0 on the next edge, thread_hit_o[i] is 1 in the cycle that follows that edge.
- R5: In failure mode, step j of a token is sampled j+1 edges after its trigger. The first missing step flags the thread for one cycle. Later steps of that same token are ignored, so the token raises no second flag.
- R6: In failure mode, a token whose steps are all present raises no flag.
- R7: verdict_o is 1 in exactly the cycles in which some bit of thread_hit_o is 1.
- R8: When a token enters a thread that still holds an earlier token, both tokens are checked independently, and each missing step still flags that thread.
- R9: In match mode, thread_hit_o[i] is 1 in the cycle after the edge that samples the last step of a token in thread i, provided every step of that token was 1. A token with any missing step never flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Precondition true this cycle; issues one token |
| steps_i | input | STEPS | Step conditions; bit j is the condition expected j+1 cycles after a trigger |
| verdict_o | output | 1 | OR of all thread flags |
| thread_hit_o | output | N_THREADS | Registered per-thread flag, for debug capture |
| ptr_o | output | N_THREADS | One-hot dispatch pointer, registered, for debug capture |

## Verification
On every cycle the assertions check the pointer: it stays one-hot, it holds when no trigger arrives, and it rotates by one when a trigger does. They also tie the verdict to the flag vector. In failure mode they check that a missing first step flags the thread the pointer selected two cycles earlier, and in match mode that any flag goes back to a trigger `STEPS`+1 cycles earlier. The bench alone can show the later-step failures, the fact that an abandoned token stays silent, tokens overlapping inside one busy thread, and exact flag vectors under long random traffic.

// File: rtl/athr_pkg.sv
package athr_pkg;
   // Variant of each replicated copy
   typedef enum logic {
      DETECT_FAIL  = 1'b0,   // consequent side: flag a missing step
      DETECT_MATCH = 1'b1    // antecedent side: flag a completed sequence
   } athr_mode_e;

   localparam int ATHR_MAX_STEPS = 8;
endpackage

// File: rtl/athr_ptr_rot.sv
module athr_ptr_rot #(
   parameter int N_THREADS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_i,
   output logic [N_THREADS-1:0] ptr_o
);
   localparam logic [N_THREADS-1:0] PTR_RST = N_THREADS'(1);

   logic [N_THREADS-1:0] ptr_q;
   logic [N_THREADS-1:0] ptr_next;

   always_comb begin
      ptr_next = ptr_q;
      if (adv_i)
         ptr_next = {ptr_q[N_THREADS-2:0], ptr_q[N_THREADS-1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= PTR_RST;
      else
         ptr_q <= ptr_next;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/athr_seq_unit.sv
module athr_seq_unit
   import athr_pkg::*;
#(
   parameter int         STEPS = 2,
   parameter athr_mode_e MODE  = DETECT_FAIL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_i,
   input  logic [STEPS-1:0] steps_i,
   output logic             hit_o
);
   // live_q[j]: a token is waiting for step j on the coming edge
   logic [STEPS-1:0] live_q;
   logic [STEPS-1:0] live_next;
   logic             hit_q;
   logic             hit_next;

   always_comb begin
      live_next[0] = tok_i;
   end

   for (genvar j = 1; j < STEPS; j++) begin : g_chain
      always_comb begin
         live_next[j] = live_q[j-1] & steps_i[j-1];
      end
   end

   if (MODE == DETECT_FAIL) begin : g_fail
      always_comb begin
         hit_next = |(live_q & ~steps_i);
      end
   end else begin : g_match
      always_comb begin
         hit_next = live_q[STEPS-1] & steps_i[STEPS-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         hit_q  <= 1'b0;
      end else begin
         live_q <= live_next;
         hit_q  <= hit_next;
      end
   end

   assign hit_o = hit_q;
endmodule

// File: rtl/athr_hit_merge.sv
module athr_hit_merge #(
   parameter int N_THREADS = 4
) (
   input  logic [N_THREADS-1:0] hits_i,
   output logic                 any_o
);
   logic [N_THREADS:0] acc;

   assign acc[0] = 1'b0;
   for (genvar t = 0; t < N_THREADS; t++) begin : g_or
      assign acc[t+1] = acc[t] | hits_i[t];
   end

   assign any_o = acc[N_THREADS];
endmodule

// File: rtl/assert_thread_dispatch.sv
module assert_thread_dispatch
   import athr_pkg::*;
#(
   parameter int         N_THREADS = 4,
   parameter int         STEPS     = 2,
   parameter athr_mode_e MODE      = DETECT_FAIL
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_i,
   input  logic [STEPS-1:0]     steps_i,
   output logic                 verdict_o,
   output logic [N_THREADS-1:0] thread_hit_o,
   output logic [N_THREADS-1:0] ptr_o
);
   if (!(N_THREADS == 2 || N_THREADS == 4 || N_THREADS == 8)) begin : g_bad_threads
      $error("assert_thread_dispatch: N_THREADS must be 2, 4 or 8");
   end
   if (STEPS < 1 || STEPS > ATHR_MAX_STEPS) begin : g_bad_steps
      $error("assert_thread_dispatch: STEPS out of range 1..8");
   end

   logic [N_THREADS-1:0] ptr;
   logic [N_THREADS-1:0] tok;
   logic [N_THREADS-1:0] hits;

   athr_ptr_rot #(
      .N_THREADS(N_THREADS)
   ) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (trig_i),
      .ptr_o (ptr)
   );

   for (genvar t = 0; t < N_THREADS; t++) begin : g_thread
      assign tok[t] = trig_i & ptr[t];

      athr_seq_unit #(
         .STEPS (STEPS),
         .MODE  (MODE)
      ) u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .tok_i   (tok[t]),
         .steps_i (steps_i),
         .hit_o   (hits[t])
      );
   end

   athr_hit_merge #(
      .N_THREADS(N_THREADS)
   ) u_merge (
      .hits_i (hits),
      .any_o  (verdict_o)
   );

   assign thread_hit_o = hits;
   assign ptr_o        = ptr;
endmodule

// File: rtl/athr_checker.sv
module athr_checker
   import athr_pkg::*;
#(
   parameter int         N_THREADS = 4,
   parameter int         STEPS     = 2,
   parameter athr_mode_e MODE      = DETECT_FAIL
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 trig_i,
   input logic                 step0_i,
   input logic                 verdict_o,
   input logic [N_THREADS-1:0] thread_hit_o,
   input logic [N_THREADS-1:0] ptr_o
);
   // cycles since reset, saturating, so $past never reaches before reset
   logic [3:0] seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= '0;
      else if (seen_q != 4'hF)
         seen_q <= seen_q + 4'd1;
   end

   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q != 0) |-> ($countones(ptr_o) == 1));

   p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q != 0 && !trig_i) |=> $stable(ptr_o));

   p_ptr_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q != 0 && trig_i) |=>
         (ptr_o == {$past(ptr_o[N_THREADS-2:0]), $past(ptr_o[N_THREADS-1])}));

   p_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q != 0) |-> (verdict_o == (thread_hit_o != '0)));

   if (MODE == DETECT_FAIL) begin : g_fail_chk
      p_first_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q >= 4'd3 && $past(trig_i, 2) && !$past(step0_i))
            |-> ((thread_hit_o & $past(ptr_o, 2)) != '0));
   end else begin : g_match_chk
      p_match_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q > 4'(STEPS + 1) && thread_hit_o != '0)
            |-> $past(trig_i, STEPS + 1));
   end
endmodule

bind assert_thread_dispatch athr_checker #(
   .N_THREADS (N_THREADS),
   .STEPS     (STEPS),
   .MODE      (MODE)
) u_athr_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig_i       (trig_i),
   .step0_i      (steps_i[0]),
   .verdict_o    (verdict_o),
   .thread_hit_o (thread_hit_o),
   .ptr_o        (ptr_o)
);

// File: tb/tb_ref_model.sv
module tb_ref_model #(
   parameter int N     = 4,
   parameter int STEPS = 2,
   parameter bit MATCH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [STEPS-1:0] steps,
   output logic [N-1:0]     exp_ptr,
   output logic [N-1:0]     exp_hit
);
   int thr_q[$];
   int age_q[$];
   int nthr[$];
   int nage[$];
   int ptr_idx;
   logic [N-1:0] nh;

   initial begin
      ptr_idx = 0;
      exp_ptr = '0;
      exp_hit = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         thr_q.delete();
         age_q.delete();
         ptr_idx = 0;
         exp_hit = '0;
      end else begin
         nh = '0;
         nthr.delete();
         nage.delete();
         foreach (thr_q[k]) begin
            if (!MATCH) begin
               if (!steps[age_q[k]])
                  nh[thr_q[k]] = 1'b1;
               else if (age_q[k] + 1 < STEPS) begin
                  nthr.push_back(thr_q[k]);
                  nage.push_back(age_q[k] + 1);
               end
            end else if (steps[age_q[k]]) begin
               if (age_q[k] + 1 == STEPS)
                  nh[thr_q[k]] = 1'b1;
               else begin
                  nthr.push_back(thr_q[k]);
                  nage.push_back(age_q[k] + 1);
               end
            end
         end
         if (trig) begin
            nthr.push_back(ptr_idx);
            nage.push_back(0);
            ptr_idx = (ptr_idx + 1) % N;
         end
         thr_q = nthr;
         age_q = nage;
         exp_hit = nh;
      end
      exp_ptr = '0;
      exp_ptr[ptr_idx] = 1'b1;
   end
endmodule

// File: tb/test_assert_thread_dispatch.sv
module test_assert_thread_dispatch;
   import athr_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig = 1'b0;
   logic [2:0] stp = '0;
   int         checks = 0;
   int         errors = 0;
   bit         running = 1'b0;
   bit         finished = 1'b0;
   string      tag = "R4";

   always #4 clk = ~clk;   // 125 MHz

   // A: 4 threads, 2 steps, failure mode
   logic       a_verdict;
   logic [3:0] a_hit, a_ptr, ea_ptr, ea_hit;
   // B: 2 threads, 3 steps, failure mode (threads get busy)
   logic       b_verdict;
   logic [1:0] b_hit, b_ptr, eb_ptr, eb_hit;
   // C: 4 threads, 2 steps, match mode
   logic       c_verdict;
   logic [3:0] c_hit, c_ptr, ec_ptr, ec_hit;

   assert_thread_dispatch #(.N_THREADS(4), .STEPS(2), .MODE(DETECT_FAIL)) i_assert_thread_dispatch (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .steps_i(stp[1:0]),
      .verdict_o(a_verdict), .thread_hit_o(a_hit), .ptr_o(a_ptr));

   assert_thread_dispatch #(.N_THREADS(2), .STEPS(3), .MODE(DETECT_FAIL)) i_assert_thread_dispatch_busy (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .steps_i(stp),
      .verdict_o(b_verdict), .thread_hit_o(b_hit), .ptr_o(b_ptr));

   assert_thread_dispatch #(.N_THREADS(4), .STEPS(2), .MODE(DETECT_MATCH)) i_assert_thread_dispatch_match (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .steps_i(stp[1:0]),
      .verdict_o(c_verdict), .thread_hit_o(c_hit), .ptr_o(c_ptr));

   tb_ref_model #(.N(4), .STEPS(2), .MATCH(1'b0)) u_ref_a (
      .clk(clk), .rst_n(rst_n), .trig(trig), .steps(stp[1:0]), .exp_ptr(ea_ptr), .exp_hit(ea_hit));
   tb_ref_model #(.N(2), .STEPS(3), .MATCH(1'b0)) u_ref_b (
      .clk(clk), .rst_n(rst_n), .trig(trig), .steps(stp), .exp_ptr(eb_ptr), .exp_hit(eb_hit));
   tb_ref_model #(.N(4), .STEPS(2), .MATCH(1'b1)) u_ref_c (
      .clk(clk), .rst_n(rst_n), .trig(trig), .steps(stp[1:0]), .exp_ptr(ec_ptr), .exp_hit(ec_hit));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // every cycle, away from the active edge
   always @(negedge clk) begin
      if (running) begin
         chk("R2 ptr A", 8'(a_ptr), 8'(ea_ptr));
         chk("R2 ptr B", 8'(b_ptr), 8'(eb_ptr));
         chk("R3 onehot A", 8'($countones(a_ptr)), 8'd1);
         chk({tag, " hits A"}, 8'(a_hit), 8'(ea_hit));
         chk("R8 hits B", 8'(b_hit), 8'(eb_hit));
         chk("R9 hits C", 8'(c_hit), 8'(ec_hit));
         chk("R7 verdict A", 8'(a_verdict), 8'(ea_hit != 0));
         chk("R7 verdict B", 8'(b_verdict), 8'(eb_hit != 0));
         chk("R7 verdict C", 8'(c_verdict), 8'(ec_hit != 0));
      end
   end

   task automatic cyc(input logic t, input logic [2:0] s);
      trig = t;
      stp  = s;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state while rst_n is held low
      chk("R1 ptr A", 8'(a_ptr), 8'h1);
      chk("R1 ptr B", 8'(b_ptr), 8'h1);
      chk("R1 hits A", 8'(a_hit), 8'h0);
      chk("R1 hits C", 8'(c_hit), 8'h0);
      chk("R1 verdict A", 8'(a_verdict), 8'h0);
      rst_n = 1'b1;
      running = 1'b1;
      cyc(0, 3'b111);
      // R4: first step missing
      tag = "R4";
      cyc(1, 3'b111);
      cyc(0, 3'b000);
      cyc(0, 3'b111);
      cyc(0, 3'b111);
      // R5: second step missing, third missing too (only one flag)
      tag = "R5";
      cyc(1, 3'b000);
      cyc(0, 3'b001);
      cyc(0, 3'b000);
      cyc(0, 3'b000);
      cyc(0, 3'b111);
      // R6: all steps present
      tag = "R6";
      cyc(1, 3'b000);
      cyc(0, 3'b111);
      cyc(0, 3'b111);
      cyc(0, 3'b111);
      cyc(0, 3'b111);
      // R2: idle holds, then wrap around with good steps
      tag = "R2";
      for (int i = 0; i < 4; i++) cyc(0, 3'b111);
      for (int i = 0; i < 9; i++) cyc(1, 3'b111);
      // R8: back-to-back triggers keep threads busy, with misses
      tag = "R8";
      cyc(1, 3'b111);
      cyc(1, 3'b110);
      cyc(1, 3'b101);
      cyc(1, 3'b011);
      cyc(0, 3'b111);
      cyc(0, 3'b000);
      cyc(0, 3'b111);
      // R9: match mode sequences mixed in
      tag = "R9";
      cyc(1, 3'b000);
      cyc(0, 3'b001);
      cyc(0, 3'b010);
      cyc(1, 3'b000);
      cyc(0, 3'b001);
      cyc(0, 3'b000);
      cyc(0, 3'b111);
      // random traffic
      tag = "R4";
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] r;
         r = 4'($urandom_range(0, 15));
         cyc(r[3] | r[0], {r[1] | r[2], r[2] | r[0], r[1] | r[3]});
      end
      // reset mid-stream returns to the reset state
      rst_n = 1'b0;
      running = 1'b0;
      cyc(1, 3'b000);
      cyc(1, 3'b000);
      chk("R1 ptr A after reset", 8'(a_ptr), 8'h1);
      chk("R1 hits B after reset", 8'(b_hit), 8'h0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule